// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sits beside a CPU bus whose address space is cut into regions by the top address byte. For each bus request it works out how many wait cycles the access costs and holds the ready line low for that many cycles. The cost depends on the region and on the kind of access: 16-bit or 32-bit, sequential or not. Sixteen region codes are defined. Codes 0 to 14 carry timing. Any code of 15 or above costs nothing.

Most regions have fixed timing. Three cartridge windows and one save-memory region are timed from a 16-bit control register. Each cartridge window covers two adjacent region codes, a base and a mirror, which always share the same timing. Only the 16-bit costs are decoded from the control register. The 32-bit costs are derived from them with simple arithmetic.

The block also tracks the region that code is currently being fetched from. It exports the non-sequential 16-bit and 32-bit cost of that region as a prefetch cost, together with the prefetch enable bit from the control register. The memories and any prefetch buffer lie outside the block.

Top module: `bus_wait_gen`

## Requirements
- R1: The region code is `req_addr[31:24]`. A region code of 15 or above yields a wait of 0 for all four access kinds.
- R2: Each cartridge window has a 2-bit non-sequential code. Code 0, 1, 2 and 3 give 4, 3, 2 and 8 wait cycles. Window 0 uses `cfg_wdata[3:2]`, window 1 uses `[6:5]` and window 2 uses `[9:8]`.
- R3: Each cartridge window has a sequential bit: window 0 uses bit 4, window 1 uses bit 7 and window 2 uses bit 10. When the bit is 1 the sequential 16-bit wait is 1. When the bit is 0 it is 2 for window 0, 4 for window 1 and 8 for window 2.
- R4: For region codes 0 to 14, the 32-bit costs follow from the 16-bit ones. Non-sequential 32-bit = N16 + S16 + 1. Sequential 32-bit = 2*S16 + 1.
- R5: Region 14 (save memory) takes its 16-bit wait from `cfg_wdata[1:0]` through the R2 code map. It uses that value for both the sequential and non-sequential 16-bit kinds, so both 32-bit kinds equal 2*value + 1.
- R6: After reset the 16-bit waits, written as N16/S16, are as follows. Regions 0, 1 and 3 to 7 are 0/0 and region 2 is 2/2. Regions 8 to 9 are 4/2, regions 10 to 11 are 4/4, regions 12 to 13 are 4/8 and region 14 is 4/4.
- R7: Window 0 covers regions 8 and 9, window 1 covers regions 10 and 11, and window 2 covers regions 12 and 13. The two regions of each pair always report identical costs.
- R8: When the selected wait is 0, `req_ready` is high in the same cycle as `req_valid`.
- R9: When the selected wait is N > 0, `req_ready` stays low for exactly N cycles, counting the first request cycle, and rises in the next cycle. The requester holds its request until ready.
- R10: A pulse on `fetch_set` makes `fetch_addr[31:24]` the active code region from the next cycle on. `pf_cost16` and `pf_cost32` give that region's non-sequential 16-bit and 32-bit waits. After reset the active region is 0.
- R11: A control write changes the prefetch costs from the next cycle on, without any new `fetch_set`.
- R12: `pf_en` follows `cfg_wdata[14]` of the last write. Control bits 11, 12, 13 and 15 have no effect on any cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request address; top byte selects the region |
| req_seq | input | 1 | Request is sequential |
| req_wide | input | 1 | Request is 32-bit (else 16-bit) |
| req_ready | output | 1 | Access completes this cycle |
| req_wait | output | 5 | Wait cost of the presented request |
| fetch_set | input | 1 | Load a new active code region |
| fetch_addr | input | 32 | Address of the new code region |
| pf_cost16 | output | 5 | Non-sequential 16-bit wait of active region |
| pf_cost32 | output | 5 | Non-sequential 32-bit wait of active region |
| pf_en | output | 1 | Prefetch enable bit from the control register |

## Verification
The bench sweeps every region code, including the first code past the table and the largest one, under the reset setting. This catches a mirror region decoded to the wrong window, and an out-of-range code that wrongly costs 1 for a 32-bit access. It steps each window through all four non-sequential codes and both sequential settings. A swapped code map or a wrong slow sequential value for one window would show up as a wrong cost in that window alone. The stall is timed for a zero wait, a wait of one and the largest wait of 17. This exposes an off-by-one counter, which would stretch or shorten the stall by a cycle. The bench also writes the control register while a cartridge region is the active code region. A prefetch cost that was sampled only when the region was set would then go stale.

// File: rtl/wsg_pkg.sv
// Package: shared types and code maps for the bus wait-state generator.
// Assumes 16-bit waits never exceed 8, so 4 bits hold them and 5 bits
// hold any derived 32-bit cost (at most 8 + 8 + 1 = 17).
package wsg_pkg;

    localparam int T16_W = 4;
    localparam int T32_W = T16_W + 1;

    // One cartridge window's decoded 16-bit timing.
    typedef struct packed {
        logic [T16_W-1:0] nseq;
        logic [T16_W-1:0] seq;
    } wait_pair_t;

    // Full cost set for one region, all four access kinds.
    typedef struct packed {
        logic [T32_W-1:0] n16;
        logic [T32_W-1:0] s16;
        logic [T32_W-1:0] n32;
        logic [T32_W-1:0] s32;
    } cost_t;

    // Access kind built from {wide, seq}.
    typedef enum logic [1:0] {
        AK_N16 = 2'b00,
        AK_S16 = 2'b01,
        AK_N32 = 2'b10,
        AK_S32 = 2'b11
    } akind_t;

    // Non-sequential code map: 0..3 -> 4, 3, 2, 8 cycles.
    function automatic logic [T16_W-1:0] nseq_wait(input logic [1:0] code);
        case (code)
            2'd0:    return T16_W'(4);
            2'd1:    return T16_W'(3);
            2'd2:    return T16_W'(2);
            default: return T16_W'(8);
        endcase
    endfunction

    // Slow sequential wait of window w: 2 << w (2, 4, 8).
    function automatic logic [T16_W-1:0] seq_slow(input int w);
        return T16_W'(2 << w);
    endfunction

endpackage

// File: rtl/wsg_cfg_reg.sv
// Module: control register and its field decode.
// Holds the timing bits of the last write and turns them into per-window
// 16-bit waits plus the save-memory wait. Reset value 0 yields the
// power-on timings. Bits 11-13 and 15 are stored nowhere.
module wsg_cfg_reg
    import wsg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int NUM_WIN  = 3,
    parameter int WIN_LSB  = 2,
    parameter int WIN_SPAN = 3,
    parameter int PF_BIT   = 14
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [CFG_W-1:0]               wdata_i,
    output wait_pair_t [NUM_WIN-1:0]       win_o,
    output logic [T16_W-1:0]               save_o,
    output logic                           pf_en_o
);
    localparam int USED_W = WIN_LSB + WIN_SPAN * NUM_WIN;

    logic [USED_W-1:0] tim_q;
    logic              pfe_q;

    // Capture timing fields and prefetch enable on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
            pfe_q <= 1'b0;
        end else if (we_i) begin
            tim_q <= wdata_i[USED_W-1:0];
            pfe_q <= wdata_i[PF_BIT];
        end
    end

    // Decode each window's pair of 16-bit waits.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int LSB = WIN_LSB + WIN_SPAN * w;
        assign win_o[w].nseq = nseq_wait(tim_q[LSB +: 2]);
        assign win_o[w].seq  = tim_q[LSB + 2] ? T16_W'(1) : seq_slow(w);
    end

    assign save_o  = nseq_wait(tim_q[1:0]);
    assign pf_en_o = pfe_q;

    // R12: prefetch enable follows the written bit one cycle later.
    a_r12_pf_follow: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> pf_en_o == $past(wdata_i[PF_BIT]));

    // R2: with no write, the decoded window timing holds still.
    a_r2_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(win_o) && $stable(save_o));

endmodule

// File: rtl/wsg_region_table.sv
// Module: per-region cost lookup.
// Maps a region code to its four wait costs. Fixed regions come from
// parameters; cartridge pairs and the save region come from the decoded
// control fields. Assumes FIRST_CART is even so each pair shares bit 0.
module wsg_region_table
    import wsg_pkg::*;
#(
    parameter int REGION_W    = 8,
    parameter int NUM_WIN     = 3,
    parameter int FIRST_CART  = 8,
    parameter int SAVE_REGION = 14,
    parameter int SLOW_REGION = 2,
    parameter int SLOW_NSEQ   = 2,
    parameter int SLOW_SEQ    = 2
) (
    input  logic [REGION_W-1:0]       region_i,
    input  wait_pair_t [NUM_WIN-1:0]  win_i,
    input  logic [T16_W-1:0]          save_i,
    output cost_t                     cost_o
);
    localparam int LIVE_LIMIT = SAVE_REGION + 1;
    localparam int PAIR_BASE  = FIRST_CART / 2;

    logic [T16_W-1:0] n16;
    logic [T16_W-1:0] s16;
    logic             live;

    // Pick the 16-bit pair for the region.
    always_comb begin
        n16  = '0;
        s16  = '0;
        live = region_i < REGION_W'(LIVE_LIMIT);
        if (region_i == REGION_W'(SLOW_REGION)) begin
            n16 = T16_W'(SLOW_NSEQ);
            s16 = T16_W'(SLOW_SEQ);
        end
        if (region_i == REGION_W'(SAVE_REGION)) begin
            n16 = save_i;
            s16 = save_i;
        end
        for (int w = 0; w < NUM_WIN; w++) begin
            if (region_i[REGION_W-1:1] == (REGION_W-1)'(PAIR_BASE + w)) begin
                n16 = win_i[w].nseq;
                s16 = win_i[w].seq;
            end
        end
    end

    // Widen the 16-bit pair and derive the 32-bit costs.
    always_comb begin
        cost_o.n16 = {1'b0, n16};
        cost_o.s16 = {1'b0, s16};
        cost_o.n32 = live ? ({1'b0, n16} + {1'b0, s16} + T32_W'(1)) : '0;
        cost_o.s32 = live ? ({s16, 1'b0} + T32_W'(1)) : '0;
    end

endmodule

// File: rtl/wsg_stall_ctr.sv
// Module: stall counter driving the ready line.
// A request with a non-zero wait starts a countdown; ready stays low for
// exactly that many cycles. Assumes the requester holds req_valid and
// its address steady until it sees ready.
module wsg_stall_ctr #(
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              ready_o
);
    logic              busy_q;
    logic [WAIT_W-1:0] cnt_q;

    // Ready: idle paths answer at once, busy path waits for the count.
    assign ready_o = busy_q ? (cnt_q == '0) : (!req_valid_i || wait_i == '0);

    // Load on a costly request, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (req_valid_i && wait_i != '0) begin
            busy_q <= 1'b1;
            cnt_q  <= wait_i - 1'b1;
        end
    end

    // R9: a costly request starts the count at wait - 1.
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && req_valid_i && wait_i != '0 |=> busy_q && cnt_q == WAIT_W'($past(wait_i) - 1'b1));

    // R9: the count falls by one each busy cycle.
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && cnt_q != '0 |=> busy_q && cnt_q == WAIT_W'($past(cnt_q) - 1'b1));

    // R9: once ready is given, the stall is over.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && ready_o |=> !busy_q);

    // R8: a zero-wait request is never stalled.
    a_r8_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && req_valid_i && wait_i == '0 |=> !busy_q);

endmodule

// File: rtl/bus_wait_gen.sv
// Module: top of the bus wait-state generator.
// Looks up the presented request's cost, stalls it through the counter,
// and tracks the active code region for the prefetch cost outputs.
// Assumes the region code is the top byte of the address.
module bus_wait_gen
    import wsg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int REGION_W = 8,
    parameter int CFG_W    = 16,
    parameter int NUM_WIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic              req_wide,
    output logic              req_ready,
    output logic [T32_W-1:0]  req_wait,
    input  logic              fetch_set,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [T32_W-1:0]  pf_cost16,
    output logic [T32_W-1:0]  pf_cost32,
    output logic              pf_en
);
    localparam int REG_LSB   = ADDR_W - REGION_W;
    localparam int LIVE_LAST = 14;

    wait_pair_t [NUM_WIN-1:0] win;
    logic [T16_W-1:0]         save_w;
    logic [REGION_W-1:0]      req_region;
    logic [REGION_W-1:0]      act_q;
    cost_t                    req_cost;
    cost_t                    pf_cost;
    akind_t                   kind;
    logic                     addr_unused;

    assign req_region  = req_addr[ADDR_W-1:REG_LSB];
    assign kind        = akind_t'({req_wide, req_seq});
    assign addr_unused = ^{req_addr[REG_LSB-1:0], fetch_addr[REG_LSB-1:0]};

    wsg_cfg_reg #(
        .CFG_W   (CFG_W),
        .NUM_WIN (NUM_WIN)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .win_o   (win),
        .save_o  (save_w),
        .pf_en_o (pf_en)
    );

    wsg_region_table #(
        .REGION_W    (REGION_W),
        .NUM_WIN     (NUM_WIN),
        .SAVE_REGION (LIVE_LAST)
    ) req_tab_i (
        .region_i (req_region),
        .win_i    (win),
        .save_i   (save_w),
        .cost_o   (req_cost)
    );

    wsg_region_table #(
        .REGION_W    (REGION_W),
        .NUM_WIN     (NUM_WIN),
        .SAVE_REGION (LIVE_LAST)
    ) pf_tab_i (
        .region_i (act_q),
        .win_i    (win),
        .save_i   (save_w),
        .cost_o   (pf_cost)
    );

    // Select the cost for the request's access kind.
    always_comb begin
        case (kind)
            AK_N16:  req_wait = req_cost.n16;
            AK_S16:  req_wait = req_cost.s16;
            AK_N32:  req_wait = req_cost.n32;
            default: req_wait = req_cost.s32;
        endcase
    end

    // Track the region code is fetched from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (fetch_set) begin
            act_q <= fetch_addr[ADDR_W-1:REG_LSB];
        end
    end

    assign pf_cost16 = pf_cost.n16;
    assign pf_cost32 = pf_cost.n32;

    wsg_stall_ctr #(
        .WAIT_W (T32_W)
    ) stall_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .wait_i      (req_wait),
        .ready_o     (req_ready)
    );

    // R1: region codes past the table cost nothing.
    a_r1_upper_free: assert property (@(posedge clk) disable iff (!rst_n)
        req_region > REGION_W'(LIVE_LAST) |-> req_wait == '0);

    // R10: a fetch_set loads the active region from the fetch address.
    a_r10_track: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_set |=> act_q == $past(fetch_addr[ADDR_W-1:REG_LSB]));

    // R11: without fetch_set the active region does not move.
    a_r11_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_set |=> $stable(act_q));

endmodule

// File: tb/bus_wait_gen_tb_top.sv
module bus_wait_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_seq = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_ready;
    logic [4:0]  req_wait;
    logic        fetch_set = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [4:0]  pf_cost16;
    logic [4:0]  pf_cost32;
    logic        pf_en;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic done = 1'b0;
    logic [15:0] cfg_m = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_wait_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_seq(req_seq),
        .req_wide(req_wide), .req_ready(req_ready), .req_wait(req_wait),
        .fetch_set(fetch_set), .fetch_addr(fetch_addr),
        .pf_cost16(pf_cost16), .pf_cost32(pf_cost32), .pf_en(pf_en)
    );

    // Reference model: code map and per-region costs.
    function automatic int ncode(input int c);
        case (c)
            0: return 4;
            1: return 3;
            2: return 2;
            default: return 8;
        endcase
    endfunction

    function automatic int m_n16(input logic [15:0] c, input int r);
        int w;
        if (r == 2) return 2;
        if (r == 14) return ncode(int'(c[1:0]));
        if (r >= 8 && r <= 13) begin
            w = (r - 8) / 2;
            return ncode(int'(c[2 + 3 * w +: 2]));
        end
        return 0;
    endfunction

    function automatic int m_s16(input logic [15:0] c, input int r);
        int w;
        if (r == 2) return 2;
        if (r == 14) return ncode(int'(c[1:0]));
        if (r >= 8 && r <= 13) begin
            w = (r - 8) / 2;
            return c[4 + 3 * w] ? 1 : (2 << w);
        end
        return 0;
    endfunction

    function automatic int m_wait(input logic [15:0] c, input int r, input bit seq, input bit wide);
        if (r >= 15) return 0;
        if (!wide) return seq ? m_s16(c, r) : m_n16(c, r);
        if (seq) return 2 * m_s16(c, r) + 1;
        return m_n16(c, r) + m_s16(c, r) + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = v;
    endtask

    // Probe the lookup for one region, all four kinds, without a request.
    task automatic probe(input string req, input int r);
        for (int k = 0; k < 4; k++) begin
            req_addr = {8'(r), 24'h3C5A96};
            req_seq  = k[0];
            req_wide = k[1];
            #1;
            check(req, int'(req_wait), m_wait(cfg_m, r, k[0], k[1]));
        end
    endtask

    // Issue a request and count the cycles ready stays low.
    task automatic do_req(input string req, input int r, input bit seq, input bit wide);
        int lows;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {8'(r), 24'h001234};
        req_seq   = seq;
        req_wide  = wide;
        lows = 0;
        #1;
        while (!req_ready && lows < 64) begin
            lows++;
            @(negedge clk);
            #1;
        end
        check(req, lows, m_wait(cfg_m, r, seq, wide));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_fetch(input int r);
        @(negedge clk);
        fetch_set = 1'b1;
        fetch_addr = {8'(r), 24'h000100};
        @(negedge clk);
        fetch_set = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R6 R10 R12: reset state of the outputs.
        check("R6 reset ready", int'(req_ready), 1);
        check("R10 reset pf_cost16", int'(pf_cost16), 0);
        check("R10 reset pf_cost32", int'(pf_cost32), 1);
        check("R12 reset pf_en", int'(pf_en), 0);

        // R6 R4 R1: default table over every region and beyond.
        for (int r = 0; r < 17; r++) probe("R6 default table", r);
        probe("R1 top region 255", 255);

        // R2 R7: every non-sequential code in every window, both mirrors.
        for (int w = 0; w < 3; w++) begin
            for (int c = 0; c < 4; c++) begin
                write_cfg(16'(c << (2 + 3 * w)));
                probe("R2 window base", 8 + 2 * w);
                probe("R7 window mirror", 9 + 2 * w);
            end
        end

        // R3: sequential bits set, then clear.
        write_cfg(16'h0490);
        for (int r = 8; r < 14; r++) probe("R3 fast seq", r);
        write_cfg(16'h0000);
        for (int r = 8; r < 14; r++) probe("R3 slow seq", r);

        // R5: save region through all codes.
        for (int c = 0; c < 4; c++) begin
            write_cfg(16'(c));
            probe("R5 save region", 14);
        end

        // R12: ignored bits change nothing; bit 14 drives pf_en.
        write_cfg(16'hB800);
        cfg_m = 16'h0000;
        #1;
        check("R12 pf_en clear", int'(pf_en), 0);
        for (int r = 8; r < 15; r++) probe("R12 ignored bits", r);
        write_cfg(16'h4000);
        #1;
        check("R12 pf_en set", int'(pf_en), 1);

        // R8 R9: directed stall lengths 0, 1 and 17.
        do_req("R8 zero wait", 0, 1'b0, 1'b0);
        do_req("R8 zero wait upper", 40, 1'b0, 1'b1);
        write_cfg(16'h0010);
        do_req("R9 wait one", 8, 1'b1, 1'b0);
        write_cfg(16'h030C);
        do_req("R9 wait max", 12, 1'b0, 1'b1);
        do_req("R9 wait seq32", 13, 1'b1, 1'b1);

        // R10 R11: prefetch cost follows region and control writes.
        set_fetch(10);
        #1;
        check("R10 pf_cost16", int'(pf_cost16), m_n16(cfg_m, 10));
        check("R10 pf_cost32", int'(pf_cost32), m_wait(cfg_m, 10, 1'b0, 1'b1));
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 16'h00E0;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_m = 16'h00E0;
        #1;
        check("R11 pf_cost16 refresh", int'(pf_cost16), 8);
        check("R11 pf_cost32 refresh", int'(pf_cost32), 10);
        set_fetch(200);
        #1;
        check("R10 pf_cost32 upper", int'(pf_cost32), 0);

        // Random mix of settings, regions and kinds.
        for (int i = 0; i < 60; i++) begin
            if (i % 6 == 0) write_cfg(16'($urandom()));
            do_req("R9 random stall", int'($urandom_range(0, 17)),
                   1'($urandom()), 1'($urandom()));
        end

        repeat (2) @(negedge clk);
        summary();
    end
endmodule